// File: doc/BRIEF.md
# Segment Descriptor Address Translator

This block turns a logical address into a 32-bit linear address. The logical address is a 16-bit selector plus a 32-bit offset. The selector chooses one of two descriptor tables and an entry within it. The block reads that 8-byte entry from memory as two 32-bit words over a simple read port, and each word waits for a valid handshake. It then unpacks the entry's base, limit, type and flag fields.

The access kind comes with the request: read, write or execute. The block checks the entry's presence and its segment class. It then checks the access kind against the segment's type code. Last, it checks the offset against the limit. Expand-up segments use one limit rule and expand-down (stack) segments use another. A finished request gives one done pulse, with either the linear address (base plus offset) or a fault code.

The bases of the two tables are plain inputs. The block takes one request at a time and raises a busy flag while it works.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `busy`, `done` and `mem_rd_en` are all low.
- R2: Selector bit 2 picks the table: 0 selects `gdt_base` and 1 selects `ldt_base`. Selector bits 15:3 give the entry index, and bits 1:0 have no effect. The low word is read at table base + index×8, and the high word is read next at that address + 4.
- R3: `mem_rd_en` stays high with a stable `mem_addr` until `mem_rvalid` is seen. Each high cycle of `mem_rvalid` while `mem_rd_en` is high completes one word.
- R4: If descriptor bit 47 (present) is 0, `fault` is 1, whatever the other fields hold.
- R5: If the entry is present and descriptor bit 44 is 0 (not a memory segment), `fault` is 2.
- R6: Access kinds are encoded as 0 = read, 1 = write, 2 = execute, and 3 = read. The type code sits in descriptor bits 43:41. `fault` is 3 in each of these cases:
  - a write to a type whose bit 2 is set (code);
  - a write to a type whose bit 2 and bit 0 are both clear (read-only data or stack);
  - an execute of a type whose bit 2 is clear;
  - a read of a type with bit 2 set and bit 0 clear (execute-only code).
- R7: The effective limit for types 0, 1 and 4–7 is computed as follows:
  - It is the 20-bit limit from descriptor bits 51:48 and 15:0.
  - If descriptor bit 55 is 1, the limit is scaled by 4096 and 4095 is added.
  - The offset must be below the effective limit, or else `fault` is 4.
- R8: For types 2 and 3 (expand-down), the offset must be above the effective limit and at most a top value, or else `fault` is 4. The top value is 0xFFFF when descriptor bit 54 is 0 and 0xFFFFFFFF when bit 54 is 1.
- R9: With no fault, `fault` is 0 and `lin_addr` is base + offset, modulo 2^32. The base comes from descriptor bits 63:56 and 39:16. When a fault is given, `lin_addr` is 0.
- R10: Each accepted request gives exactly one one-cycle `done` pulse. `busy` rises in the cycle after acceptance and stays high through the `done` cycle. The fault priority is present, then class, then rights, then limit.
- R11: `req_valid` has no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_sel | input | 16 | Selector: index, table bit, privilege bits |
| req_off | input | 32 | Offset within the segment |
| req_kind | input | 2 | Access kind (0 read, 1 write, 2 execute, 3 read) |
| gdt_base | input | 32 | Base address of the global table |
| ldt_base | input | 32 | Base address of the local table |
| mem_rd_en | output | 1 | Word read request |
| mem_addr | output | 32 | Word read address |
| mem_rvalid | input | 1 | Read data valid handshake |
| mem_rdata | input | 32 | Read data word |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 3 | Fault code, valid with done |
| lin_addr | output | 32 | Linear address, valid with done |

## Verification
The translation is tried with several kinds of segment:
- expand-up data segments with byte and page granularity;
- code segments of each rights flavour;
- expand-down segments with both top values;
- entries that are not present or are system entries.

Offsets sit exactly on, one below and one above each bound, which separates the open and closed ends of each range. Entries that break several rules at once show that the fault priority is right. A memory latency of zero is compared with a latency of several cycles to check the handshake. Local-table selectors and the maximum index check the address arithmetic. A request driven while busy shows that it is ignored.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int WORD_W   = 32;
    localparam int SEL_W    = 16;
    localparam int IDX_W    = 13;
    localparam int DESC_W   = 2 * WORD_W;
    localparam int LIM_W    = 20;
    localparam int PAGE_SH  = 12;
    localparam int TYPE_W   = 3;
    localparam int FAULT_W  = 3;
    localparam int TI_BIT   = 2;
    localparam int ENTRY_SH = 3;

    typedef enum logic [1:0] {
        ACC_READ   = 2'd0,
        ACC_WRITE  = 2'd1,
        ACC_EXEC   = 2'd2,
        ACC_READ_B = 2'd3
    } acc_t;

    typedef enum logic [FAULT_W-1:0] {
        FLT_NONE   = 3'd0,
        FLT_ABSENT = 3'd1,
        FLT_SYSTEM = 3'd2,
        FLT_RIGHTS = 3'd3,
        FLT_BOUNDS = 3'd4
    } fault_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_FIN
    } fsm_t;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [WORD_W-1:0] off;
        acc_t              acc;
    } req_t;

    typedef struct packed {
        logic [WORD_W-1:0] base;
        logic [LIM_W-1:0]  limit;
        logic [TYPE_W-1:0] kind;
        logic              mem_seg;
        logic              present;
        logic              big;
        logic              gran;
    } desc_t;

    // class helpers on the 3-bit type code
    function automatic logic is_code(input logic [TYPE_W-1:0] t);
        return t[2];
    endfunction

    function automatic logic is_down(input logic [TYPE_W-1:0] t);
        return !t[2] && t[1];
    endfunction

    function automatic logic rights_bad(input logic [TYPE_W-1:0] t, input acc_t a);
        logic bad;
        case (a)
            ACC_WRITE: bad = is_code(t) || !t[0];
            ACC_EXEC:  bad = !is_code(t);
            default:   bad = is_code(t) && !t[0];
        endcase
        return bad;
    endfunction

endpackage

// File: rtl/seg_fetch.sv
module seg_fetch
    import seg_xlate_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  req_t              req_in,
    input  logic [AW-1:0]     gdt_base,
    input  logic [AW-1:0]     ldt_base,
    output logic              mem_rd_en,
    output logic [AW-1:0]     mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              busy,
    output logic              fin,
    output req_t              req_q,
    output logic [DESC_W-1:0] raw_desc
);

    localparam logic [AW-1:0] HALF_STEP = AW'(WORD_W / 8);

    fsm_t              st;
    logic [AW-1:0]     daddr;
    logic [WORD_W-1:0] lo_q;
    logic [WORD_W-1:0] hi_q;
    logic [AW-1:0]     tbl_base;
    logic [IDX_W-1:0]  idx;

    assign idx      = req_in.sel[SEL_W-1:ENTRY_SH];
    assign tbl_base = req_in.sel[TI_BIT] ? ldt_base : gdt_base;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            daddr <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
            req_q <= '0;
        end else begin
            case (st)
                ST_IDLE: if (req_valid) begin
                    req_q <= req_in;
                    daddr <= tbl_base + AW'({idx, {ENTRY_SH{1'b0}}});
                    st    <= ST_LOW;
                end
                ST_LOW: if (mem_rvalid) begin
                    lo_q <= mem_rdata;
                    st   <= ST_HIGH;
                end
                ST_HIGH: if (mem_rvalid) begin
                    hi_q <= mem_rdata;
                    st   <= ST_FIN;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign mem_rd_en = (st == ST_LOW) || (st == ST_HIGH);
    assign mem_addr  = daddr + ((st == ST_HIGH) ? HALF_STEP : '0);
    assign busy      = (st != ST_IDLE);
    assign fin       = (st == ST_FIN);
    assign raw_desc  = {hi_q, lo_q};

endmodule

// File: rtl/seg_decode.sv
module seg_decode
    import seg_xlate_pkg::*;
(
    input  logic [DESC_W-1:0] raw,
    output desc_t             fields
);

    always_comb begin
        fields.base    = {raw[63:56], raw[39:16]};
        fields.limit   = {raw[51:48], raw[15:0]};
        fields.kind    = raw[43:41];
        fields.mem_seg = raw[44];
        fields.present = raw[47];
        fields.big     = raw[54];
        fields.gran    = raw[55];
    end

    // accessed, privilege, spare bits carry no meaning here
    logic unused_desc_bits;
    assign unused_desc_bits = &{1'b0, raw[40], raw[46:45], raw[53:52]};

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlate_pkg::*;
(
    input  desc_t             d,
    input  logic [WORD_W-1:0] off,
    input  acc_t              acc,
    output fault_t            flt,
    output logic [WORD_W-1:0] lin
);

    localparam int PAD_W = WORD_W - LIM_W;

    logic [WORD_W-1:0] eff_lim;
    logic [WORD_W-1:0] top;
    logic              in_range;

    always_comb begin
        if (d.gran)
            eff_lim = {d.limit, {PAGE_SH{1'b1}}};
        else
            eff_lim = {{PAD_W{1'b0}}, d.limit};
        top = d.big ? {WORD_W{1'b1}} : WORD_W'(32'h0000_FFFF);
        if (is_down(d.kind))
            in_range = (off > eff_lim) && (off <= top);
        else
            in_range = (off < eff_lim);
    end

    always_comb begin
        flt = FLT_NONE;
        if (!d.present)
            flt = FLT_ABSENT;
        else if (!d.mem_seg)
            flt = FLT_SYSTEM;
        else if (rights_bad(d.kind, acc))
            flt = FLT_RIGHTS;
        else if (!in_range)
            flt = FLT_BOUNDS;
    end

    assign lin = d.base + off;

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [15:0] req_sel,
    input  logic [31:0] req_off,
    input  logic [1:0]  req_kind,
    input  logic [31:0] gdt_base,
    input  logic [31:0] ldt_base,
    output logic        mem_rd_en,
    output logic [31:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    output logic        busy,
    output logic        done,
    output logic [2:0]  fault,
    output logic [31:0] lin_addr
);

    req_t              req_in;
    req_t              req_q;
    logic [DESC_W-1:0] raw_desc;
    desc_t             fields;
    fault_t            flt;
    logic [WORD_W-1:0] lin;
    logic              fin;

    assign req_in.sel = req_sel;
    assign req_in.off = req_off;
    assign req_in.acc = acc_t'(req_kind);

    seg_fetch #(.AW(WORD_W)) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_in     (req_in),
        .gdt_base   (gdt_base),
        .ldt_base   (ldt_base),
        .mem_rd_en  (mem_rd_en),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .busy       (busy),
        .fin        (fin),
        .req_q      (req_q),
        .raw_desc   (raw_desc)
    );

    seg_decode u_decode (
        .raw    (raw_desc),
        .fields (fields)
    );

    seg_check u_check (
        .d   (fields),
        .off (req_q.off),
        .acc (req_q.acc),
        .flt (flt),
        .lin (lin)
    );

    // requested privilege bits and index are consumed upstream only
    logic unused_sel_bits;
    assign unused_sel_bits = &{1'b0, req_q.sel};

    assign done     = fin;
    assign fault    = fin ? flt : FLT_NONE;
    assign lin_addr = (fin && flt == FLT_NONE) ? lin : '0;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        busy,
    input logic        done,
    input logic [2:0]  fault,
    input logic [31:0] lin_addr,
    input logic        mem_rd_en,
    input logic        mem_rvalid,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_rdata
);

    logic [1:0]  hs;
    logic [31:0] hi_w;

    always_ff @(posedge clk) begin
        if (rst || (req_valid && !busy)) begin
            hs   <= '0;
            hi_w <= '0;
        end else if (mem_rd_en && mem_rvalid) begin
            if (hs == 2'd1) hi_w <= mem_rdata;
            hs <= hs + 2'd1;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!done && !mem_rd_en));

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && !mem_rvalid) |=> (mem_rd_en && $stable(mem_addr)));

    assert_absent_first_R4: assert property (@(posedge clk) disable iff (rst)
        (done && !hi_w[15]) |-> (fault == 3'd1));

    assert_system_entry_R5: assert property (@(posedge clk) disable iff (rst)
        (done && hi_w[15] && !hi_w[12]) |-> (fault == 3'd2));

    assert_fault_zero_addr_R9: assert property (@(posedge clk) disable iff (rst)
        (done && fault != 3'd0) |-> (lin_addr == 32'd0));

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_cover_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_valid));

    assert_busy_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

endmodule

bind seg_xlate seg_xlate_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .busy       (busy),
    .done       (done),
    .fault      (fault),
    .lin_addr   (lin_addr),
    .mem_rd_en  (mem_rd_en),
    .mem_rvalid (mem_rvalid),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata)
);

// File: tb/sim_seg_xlate.sv
module sim_seg_xlate;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] GDT = 32'h0000_1000;
    localparam logic [31:0] LDT = 32'h0002_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] req_sel = '0;
    logic [31:0] req_off = '0;
    logic [1:0]  req_kind = '0;
    logic        mem_rd_en;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        busy, done;
    logic [2:0]  fault;
    logic [31:0] lin_addr;

    int n_cmp = 0;
    int n_bad = 0;
    int mem_lat = 0;
    bit finished = 0;
    string cur_tag = "R9";

    logic [31:0] mem [logic [31:0]];

    // reference model state
    bit          m_busy = 0;
    bit          m_done = 0;
    int          m_ph = 0;
    logic [31:0] m_daddr = '0;
    logic [2:0]  m_flt = '0;
    logic [31:0] m_lin = '0;
    string       m_tag = "";

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_xlate u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_sel(req_sel),
        .req_off(req_off), .req_kind(req_kind), .gdt_base(GDT), .ldt_base(LDT),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .fault(fault),
        .lin_addr(lin_addr)
    );

    task automatic cmp(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'hDEAD_BEEF;
    endfunction

    function automatic logic [63:0] mk_desc(input logic [31:0] base, input logic [19:0] lim,
        input logic [2:0] typ, input bit s, input bit p, input bit dbit, input bit g);
        logic [63:0] d;
        d = '0;
        d[15:0]  = lim[15:0];
        d[39:16] = base[23:0];
        d[40]    = 1'b1;
        d[43:41] = typ;
        d[44]    = s;
        d[46:45] = 2'b11;
        d[47]    = p;
        d[51:48] = lim[19:16];
        d[54]    = dbit;
        d[55]    = g;
        d[63:56] = base[31:24];
        return d;
    endfunction

    task automatic put(input logic [31:0] tbl, input int idx, input logic [63:0] d);
        logic [31:0] a;
        a = tbl + 32'(idx) * 8;
        mem[a]     = d[31:0];
        mem[a + 4] = d[63:32];
    endtask

    function automatic logic [15:0] mksel(input int idx, input bit ti);
        logic [12:0] i;
        i = 13'(idx);
        return {i, ti, 2'b10};
    endfunction

    // behavioural expectation straight from the requirements
    function automatic logic [34:0] expect_res(input logic [63:0] d, input logic [31:0] off,
                                               input logic [1:0] k);
        longint unsigned lim, top, o;
        logic [2:0] t;
        bit code, down, ok;
        logic [31:0] base;
        if (d[47] == 1'b0) return {3'd1, 32'd0};
        if (d[44] == 1'b0) return {3'd2, 32'd0};
        t = d[43:41];
        code = (t >= 3'd4);
        down = (t == 3'd2) || (t == 3'd3);
        if (k == 2'd1 && (code || t[0] == 1'b0)) return {3'd3, 32'd0};
        if (k == 2'd2 && !code) return {3'd3, 32'd0};
        if ((k == 2'd0 || k == 2'd3) && (t == 3'd4 || t == 3'd6)) return {3'd3, 32'd0};
        lim = longint'({d[51:48], d[15:0]});
        if (d[55]) lim = lim * 4096 + 4095;
        o = longint'(off);
        if (down) begin
            top = d[54] ? 64'hFFFF_FFFF : 64'hFFFF;
            ok = (o > lim) && (o <= top);
        end else begin
            ok = (o < lim);
        end
        if (!ok) return {3'd4, 32'd0};
        base = {d[63:56], d[39:16]};
        return {3'd0, base + off};
    endfunction

    // memory responder: inputs change just after the rising edge
    initial begin
        int cnt = 0;
        forever begin
            @(posedge clk); #1;
            if (mem_rvalid) begin
                mem_rvalid = 1'b0;
                cnt = 0;
            end else if (mem_rd_en) begin
                if (cnt >= mem_lat) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = rd(mem_addr);
                end else begin
                    cnt++;
                end
            end else begin
                cnt = 0;
            end
        end
    end

    // cycle model, compared on every falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (rst) begin
                m_busy = 0; m_done = 0; m_ph = 0;
            end else if (!finished) begin
                cmp("R10", "busy", 32'(busy), 32'(m_busy));
                cmp("R10", "done", 32'(done), 32'(m_done));
                cmp("R3", "rd_en", 32'(mem_rd_en), 32'(m_ph != 0));
                if (m_ph != 0)
                    cmp("R2", "mem_addr", mem_addr, m_daddr + ((m_ph == 2) ? 32'd4 : 32'd0));
                if (m_done) begin
                    cmp(m_tag, "fault", 32'(fault), 32'(m_flt));
                    cmp(m_tag == "R4" || m_tag == "R5" || m_tag == "R6" ? "R9" : m_tag,
                        "lin_addr", lin_addr, m_lin);
                end
                if (m_done) begin
                    m_done = 0; m_busy = 0; m_ph = 0;
                end else if (m_ph == 1 && mem_rvalid) begin
                    m_ph = 2;
                end else if (m_ph == 2 && mem_rvalid) begin
                    m_ph = 0; m_done = 1;
                end else if (!m_busy && req_valid) begin
                    logic [34:0] r;
                    m_busy  = 1;
                    m_ph    = 1;
                    m_tag   = cur_tag;
                    m_daddr = (req_sel[2] ? LDT : GDT) + {16'd0, req_sel[15:3], 3'b000};
                    r = expect_res({rd(m_daddr + 4), rd(m_daddr)}, req_off, req_kind);
                    m_flt = r[34:32];
                    m_lin = r[31:0];
                end
            end
        end
    end

    task automatic go(input logic [15:0] sel, input logic [31:0] off, input logic [1:0] k,
                      input string tag);
        int guard;
        cur_tag = tag;
        @(posedge clk); #1;
        req_valid = 1'b1; req_sel = sel; req_off = off; req_kind = k;
        @(posedge clk); #1;
        req_valid = 1'b0;
        guard = 0;
        while (m_busy && guard < 200) begin
            @(posedge clk);
            guard++;
        end
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        put(GDT, 1,    mk_desc(32'h0010_0000, 20'h00FFF, 3'b001, 1, 1, 0, 0));
        put(GDT, 2,    mk_desc(32'h0020_0000, 20'h0FFFF, 3'b000, 1, 1, 0, 0));
        put(GDT, 3,    mk_desc(32'h0030_0000, 20'hFFFFF, 3'b100, 1, 1, 0, 0));
        put(GDT, 4,    mk_desc(32'h0040_0000, 20'h00010, 3'b101, 1, 1, 0, 1));
        put(GDT, 5,    mk_desc(32'h0000_0000, 20'h00000, 3'b000, 0, 0, 0, 0));
        put(GDT, 6,    mk_desc(32'h0050_0000, 20'h00FFF, 3'b001, 0, 1, 0, 0));
        put(GDT, 7,    mk_desc(32'h0050_0000, 20'h00FFF, 3'b011, 1, 1, 0, 0));
        put(GDT, 8,    mk_desc(32'hF000_0000, 20'h0FFFF, 3'b010, 1, 1, 1, 0));
        put(GDT, 8191, mk_desc(32'h0000_0000, 20'hFFFFF, 3'b001, 1, 1, 0, 1));
        put(LDT, 3,    mk_desc(32'h0060_0000, 20'h00100, 3'b111, 1, 1, 0, 0));

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        cmp("R1", "busy", 32'(busy), 32'd0);
        cmp("R1", "done", 32'(done), 32'd0);
        cmp("R1", "rd_en", 32'(mem_rd_en), 32'd0);

        // expand-up byte limit, open upper end
        go(mksel(1, 0), 32'h0000_0100, 2'd0, "R9");
        go(mksel(1, 0), 32'h0000_0FFE, 2'd1, "R7");
        go(mksel(1, 0), 32'h0000_0FFF, 2'd0, "R7");
        // page granularity
        go(mksel(8191, 0), 32'hFFFF_FFFE, 2'd1, "R7");
        go(mksel(4, 0), 32'h0001_0FFE, 2'd2, "R7");
        go(mksel(4, 0), 32'h0001_0FFF, 2'd2, "R7");
        // rights
        go(mksel(2, 0), 32'h0000_0010, 2'd1, "R6");
        go(mksel(3, 0), 32'h0000_0010, 2'd0, "R6");
        go(mksel(3, 0), 32'h0000_0010, 2'd3, "R6");
        go(mksel(1, 0), 32'h0000_0010, 2'd2, "R6");
        go(mksel(4, 0), 32'h0000_0010, 2'd1, "R6");
        go(mksel(2, 0), 32'h0010_0000, 2'd1, "R6");
        go(mksel(3, 0), 32'h0000_0040, 2'd2, "R9");
        // presence and class priority
        go(mksel(5, 0), 32'hFFFF_FFFF, 2'd2, "R4");
        go(mksel(6, 0), 32'h0000_0010, 2'd0, "R5");
        // expand-down, both tops
        go(mksel(7, 0), 32'h0000_1000, 2'd1, "R8");
        go(mksel(7, 0), 32'h0000_0FFF, 2'd0, "R8");
        go(mksel(7, 0), 32'h0000_FFFF, 2'd0, "R8");
        go(mksel(7, 0), 32'h0001_0000, 2'd0, "R8");
        go(mksel(8, 0), 32'hFFFF_FFFF, 2'd0, "R8");
        go(mksel(8, 0), 32'h0001_0000, 2'd0, "R8");
        go(mksel(8, 0), 32'h0000_FFFF, 2'd0, "R8");
        // local table with slow memory
        mem_lat = 3;
        go(mksel(3, 1), 32'h0000_00FF, 2'd0, "R2");
        go(mksel(3, 1), 32'h0000_0100, 2'd2, "R3");
        go(mksel(8191, 0), 32'h1234_5678, 2'd0, "R2");

        // request while busy is ignored
        cur_tag = "R11";
        @(posedge clk); #1;
        req_valid = 1'b1; req_sel = mksel(7, 0); req_off = 32'h0000_2000; req_kind = 2'd1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(posedge clk); #1;
        req_valid = 1'b1; req_sel = mksel(1, 0); req_off = 32'h0000_0004; req_kind = 2'd2;
        @(posedge clk); #1;
        req_valid = 1'b0;
        begin
            int guard = 0;
            while (m_busy && guard < 200) begin @(posedge clk); guard++; end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp("R11", "busy_after", 32'(busy), 32'd0);

        mem_lat = 0;
        go(mksel(1, 0), 32'h0000_0000, 2'd0, "R10");
        repeat (2) @(posedge clk);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule